// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block decides, in every cycle, which hardware thread of a multithreaded out-of-order core may retire its next instruction. For each thread it looks at whether the thread is active, the thread's commit state, whether the thread's reorder buffer is empty, whether the oldest entry of that buffer is ready, and the sequence number of that oldest entry. It then reports either one thread index or that no thread can retire.

A static policy input selects how the selector chooses among the ready threads. The first option always favours the oldest instruction. The second option keeps an ordered priority list and rotates it. The third option is the oldest-first choice used once per retire slot. The commit datapath pulses an accept strobe when it actually used the offered thread. Only that pulse rotates the round-robin list, so an offer that is not taken leaves the order as it was. When the block is built for a single thread, it skips the policies and only checks the commit state of thread 0.

Top module: `sc_commit_select`

## Requirements
- R1: A thread can be granted only if its 3-bit commit state (bits [3t+2:3t] of `thr_status`) is 0 (idle), 1 (running) or 4 (waiting on a fetch-side trap). Codes 2 (buffer squashing), 3 (waiting on a trap) and 5 to 7 exclude the thread.
- R2: A thread can be granted only if its bit in `thr_active` is 1, its bit in `head_ready` is 1 and its bit in `rob_empty` is 0.
- R3: If no thread qualifies, `grant_valid` is 0 and `grant_tid` is 0.
- R4: With `policy` = 2 (oldest-ready), or 3, which acts the same, the grant goes to the qualifying thread with the smallest head sequence number, where thread t's number is `head_seq[SEQ_W*t +: SEQ_W]`.
- R5: Under the oldest-first choice, equal sequence numbers resolve to the lowest thread index.
- R6: With `policy` = 0 (aggressive), the grant is the same as under the oldest-ready policy.
- R7: With `policy` = 1 (round-robin), the block scans its priority list from the front and grants the first qualifying thread.
- R8: After reset the priority list holds the thread indices in ascending order, so thread 0 is at the front.
- R9: A rising clock edge with `grant_accept` = 1, `grant_valid` = 1 and `policy` = 1 moves the granted thread to the back of the list. The other threads keep their relative order.
- R10: Without that combination, the list does not change. This covers edges with `grant_accept` = 0, and edges that occur under another policy.
- R11: When built with NUM_THREADS = 1, `grant_valid` is 1 exactly when thread 0 is active and its state is 0, 1 or 4, regardless of the head-ready and empty flags. `grant_tid` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | 0 aggressive, 1 round-robin, 2 oldest-ready, 3 same as 2 |
| thr_active | input | NUM_THREADS | Per-thread active mask |
| thr_status | input | 3*NUM_THREADS | Per-thread commit state codes |
| rob_empty | input | NUM_THREADS | Per-thread reorder buffer empty flag |
| head_ready | input | NUM_THREADS | Per-thread oldest entry ready flag |
| head_seq | input | SEQ_W*NUM_THREADS | Per-thread sequence number of the oldest entry |
| grant_accept | input | 1 | The offered grant was used this cycle |
| grant_valid | output | 1 | A thread is granted |
| grant_tid | output | TID_W | Index of the granted thread |

## Verification
In one cycle, the selector can both offer a grant and see that grant accepted. It can also see the policy, the eligibility or the sequence numbers change right after a rotation. The bench causes this by pulsing `grant_accept` while the policy moves between round-robin and the others, and while the thread states are randomised. Some of those pulses arrive with no thread eligible. A behavioural queue model predicts every offer and applies each rotation only on an accepted round-robin grant. The bench compares the offer in each cycle, so a wrong rotation shows up as a wrong thread index in a later cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [2:0] {
        CS_IDLE            = 3'd0,
        CS_RUNNING         = 3'd1,
        CS_ROB_SQUASH      = 3'd2,
        CS_TRAP_WAIT       = 3'd3,
        CS_FETCH_TRAP_WAIT = 3'd4
    } commit_state_e;

    typedef enum logic [1:0] {
        POL_AGGRESSIVE = 2'd0,
        POL_ROUND_ROBIN = 2'd1,
        POL_OLDEST      = 2'd2
    } select_policy_e;

    localparam int STATE_W = 3;

    // States in which a thread's head entry may be retired.
    function automatic logic state_can_commit(input logic [STATE_W-1:0] s);
        return (s == CS_IDLE) || (s == CS_RUNNING) || (s == CS_FETCH_TRAP_WAIT);
    endfunction

    function automatic int tid_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sc_eligibility.sv
module sc_eligibility
    import sc_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS-1:0]         thr_active,
    input  logic [NUM_THREADS*STATE_W-1:0] thr_status,
    input  logic [NUM_THREADS-1:0]         rob_empty,
    input  logic [NUM_THREADS-1:0]         head_ready,
    output logic [NUM_THREADS-1:0]         state_ok,
    output logic [NUM_THREADS-1:0]         eligible
);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign state_ok[t] = thr_active[t] &&
                             state_can_commit(thr_status[t*STATE_W +: STATE_W]);
        assign eligible[t] = state_ok[t] && head_ready[t] && !rob_empty[t];
    end

endmodule

// File: rtl/sc_oldest_pick.sv
module sc_oldest_pick #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0]       eligible,
    input  logic [NUM_THREADS*SEQ_W-1:0] head_seq,
    output logic                         pick_valid,
    output logic [TID_W-1:0]             pick_tid
);

    logic [SEQ_W-1:0] best_seq;

    // Strict less-than keeps the lower index on equal sequence numbers.
    always_comb begin
        pick_valid = 1'b0;
        pick_tid   = '0;
        best_seq   = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (eligible[t] &&
                (!pick_valid || head_seq[t*SEQ_W +: SEQ_W] < best_seq)) begin
                pick_valid = 1'b1;
                pick_tid   = TID_W'(t);
                best_seq   = head_seq[t*SEQ_W +: SEQ_W];
            end
        end
    end

endmodule

// File: rtl/sc_rr_order.sv
module sc_rr_order #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] eligible,
    input  logic                   rotate_en,
    output logic                   pick_valid,
    output logic [TID_W-1:0]       pick_tid
);

    logic [TID_W-1:0] order_q [NUM_THREADS];
    logic [TID_W-1:0] order_d [NUM_THREADS];
    logic [TID_W-1:0] hit_pos;

    // Scan list from the front for the first eligible thread.
    always_comb begin
        pick_valid = 1'b0;
        pick_tid   = '0;
        hit_pos    = '0;
        for (int p = 0; p < NUM_THREADS; p++) begin
            if (!pick_valid && eligible[order_q[p]]) begin
                pick_valid = 1'b1;
                pick_tid   = order_q[p];
                hit_pos    = TID_W'(p);
            end
        end
    end

    // Remove the granted entry, close the gap, append it at the tail.
    always_comb begin
        for (int k = 0; k < NUM_THREADS - 1; k++) begin
            order_d[k] = (k < int'(hit_pos)) ? order_q[k] : order_q[k+1];
        end
        order_d[NUM_THREADS-1] = order_q[hit_pos];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_THREADS; k++) begin
                order_q[k] <= TID_W'(k);
            end
        end else if (rotate_en && pick_valid) begin
            for (int k = 0; k < NUM_THREADS; k++) begin
                order_q[k] <= order_d[k];
            end
        end
    end

endmodule

// File: rtl/sc_commit_select.sv
module sc_commit_select
    import sc_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    parameter int TID_W       = sc_pkg::tid_width(NUM_THREADS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [1:0]                     policy,
    input  logic [NUM_THREADS-1:0]         thr_active,
    input  logic [NUM_THREADS*STATE_W-1:0] thr_status,
    input  logic [NUM_THREADS-1:0]         rob_empty,
    input  logic [NUM_THREADS-1:0]         head_ready,
    input  logic [NUM_THREADS*SEQ_W-1:0]   head_seq,
    input  logic                           grant_accept,
    output logic                           grant_valid,
    output logic [TID_W-1:0]               grant_tid
);

    logic [NUM_THREADS-1:0] state_ok;
    logic [NUM_THREADS-1:0] eligible;

    sc_eligibility #(.NUM_THREADS(NUM_THREADS)) u_elig (
        .thr_active (thr_active),
        .thr_status (thr_status),
        .rob_empty  (rob_empty),
        .head_ready (head_ready),
        .state_ok   (state_ok),
        .eligible   (eligible)
    );

    if (NUM_THREADS == 1) begin : g_single
        // One thread: no policy, only the state of thread 0 matters.
        assign grant_valid = state_ok[0];
        assign grant_tid   = '0;
    end else begin : g_multi
        logic             old_valid;
        logic [TID_W-1:0] old_tid;
        logic             rr_valid;
        logic [TID_W-1:0] rr_tid;
        logic             rr_mode;

        assign rr_mode = (policy == POL_ROUND_ROBIN);

        sc_oldest_pick #(
            .NUM_THREADS (NUM_THREADS),
            .SEQ_W       (SEQ_W),
            .TID_W       (TID_W)
        ) u_oldest (
            .eligible   (eligible),
            .head_seq   (head_seq),
            .pick_valid (old_valid),
            .pick_tid   (old_tid)
        );

        sc_rr_order #(
            .NUM_THREADS (NUM_THREADS),
            .TID_W       (TID_W)
        ) u_rr (
            .clk        (clk),
            .rst        (rst),
            .eligible   (eligible),
            .rotate_en  (rr_mode && grant_accept),
            .pick_valid (rr_valid),
            .pick_tid   (rr_tid)
        );

        // Aggressive and oldest-ready share the age comparator.
        always_comb begin
            if (rr_mode) begin
                grant_valid = rr_valid;
                grant_tid   = rr_tid;
            end else begin
                grant_valid = old_valid;
                grant_tid   = old_tid;
            end
        end
    end

endmodule

// File: rtl/sc_commit_select_chk.sv
module sc_commit_select_chk
    import sc_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    parameter int TID_W       = sc_pkg::tid_width(NUM_THREADS)
) (
    input logic                           clk,
    input logic                           rst,
    input logic [1:0]                     policy,
    input logic [NUM_THREADS-1:0]         thr_active,
    input logic [NUM_THREADS*STATE_W-1:0] thr_status,
    input logic [NUM_THREADS-1:0]         rob_empty,
    input logic [NUM_THREADS-1:0]         head_ready,
    input logic [NUM_THREADS*SEQ_W-1:0]   head_seq,
    input logic                           grant_accept,
    input logic                           grant_valid,
    input logic [TID_W-1:0]               grant_tid
);

    logic [NUM_THREADS-1:0] elig_c;
    logic [NUM_THREADS-1:0] stok_c;
    logic                   older_seen;
    logic [SEQ_W-1:0]       gseq;

    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            stok_c[t] = thr_active[t] && state_can_commit(thr_status[t*STATE_W +: STATE_W]);
            elig_c[t] = stok_c[t] && head_ready[t] && !rob_empty[t];
        end
        gseq = head_seq[int'(grant_tid)*SEQ_W +: SEQ_W];
        older_seen = 1'b0;
        for (int j = 0; j < NUM_THREADS; j++) begin
            if (elig_c[j] && (head_seq[j*SEQ_W +: SEQ_W] < gseq ||
                (head_seq[j*SEQ_W +: SEQ_W] == gseq && j < int'(grant_tid))))
                older_seen = 1'b1;
        end
    end

    if (NUM_THREADS > 1) begin : g_multi_chk
        // R1 and R2: an offered thread must qualify.
        a_r1_grant_qualifies: assert property (@(posedge clk) disable iff (rst)
            grant_valid |-> elig_c[grant_tid]);

        // R3: nothing qualifies means no offer.
        a_r3_none_when_idle: assert property (@(posedge clk) disable iff (rst)
            (elig_c == '0) |-> (!grant_valid && grant_tid == '0));

        // R4, R5 and R6: age-based policies never skip an older qualifier.
        a_r4_oldest_first: assert property (@(posedge clk) disable iff (rst)
            (grant_valid && policy != POL_ROUND_ROBIN) |-> !older_seen);

        // R10: without an accept the round-robin offer does not move.
        a_r10_hold_without_accept: assert property (@(posedge clk) disable iff (rst)
            (policy == POL_ROUND_ROBIN && $past(policy) == POL_ROUND_ROBIN &&
             !$past(grant_accept) && $stable(elig_c))
            |-> ($stable(grant_tid) && $stable(grant_valid)));
    end else begin : g_single_chk
        // R11: single-thread build follows thread 0's state only.
        a_r11_single_thread: assert property (@(posedge clk) disable iff (rst)
            (grant_valid == stok_c[0]) && grant_tid == '0);
    end

endmodule

bind sc_commit_select sc_commit_select_chk #(
    .NUM_THREADS (NUM_THREADS),
    .SEQ_W       (SEQ_W),
    .TID_W       (TID_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .policy       (policy),
    .thr_active   (thr_active),
    .thr_status   (thr_status),
    .rob_empty    (rob_empty),
    .head_ready   (head_ready),
    .head_seq     (head_seq),
    .grant_accept (grant_accept),
    .grant_valid  (grant_valid),
    .grant_tid    (grant_tid)
);

// File: tb/sim_sc_commit_select.sv
module sim_sc_commit_select;

    localparam int N  = 4;
    localparam int SW = 8;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [1:0]      pol = 2'd2;
    logic [N-1:0]    act = '0, emp = '0, rdy = '0;
    logic [N*3-1:0]  stat = '0;
    logic [N*SW-1:0] seq = '0;
    logic            acc = 1'b0;
    logic            gv;
    logic [TW-1:0]   gt;

    logic            s_act = 1'b0, s_emp = 1'b0, s_rdy = 1'b0, s_acc = 1'b0;
    logic [2:0]      s_stat = '0;
    logic [SW-1:0]   s_seq = '0;
    logic            s_gv;
    logic [0:0]      s_gt;

    sc_commit_select #(.NUM_THREADS(N), .SEQ_W(SW)) u0 (
        .clk(clk), .rst(rst), .policy(pol), .thr_active(act), .thr_status(stat),
        .rob_empty(emp), .head_ready(rdy), .head_seq(seq), .grant_accept(acc),
        .grant_valid(gv), .grant_tid(gt));

    sc_commit_select #(.NUM_THREADS(1), .SEQ_W(SW)) u1 (
        .clk(clk), .rst(rst), .policy(pol), .thr_active(s_act), .thr_status(s_stat),
        .rob_empty(s_emp), .head_ready(s_rdy), .head_seq(s_seq), .grant_accept(s_acc),
        .grant_valid(s_gv), .grant_tid(s_gt));

    int checks = 0;
    int errors = 0;
    int rr_q[$];

    function automatic bit qual(int t);
        int s;
        s = int'(stat[t*3 +: 3]);
        return act[t] && (s == 0 || s == 1 || s == 4) && rdy[t] && !emp[t];
    endfunction

    function automatic void model(output bit ev, output int et);
        ev = 0; et = 0;
        if (pol == 2'd1) begin
            foreach (rr_q[i]) if (!ev && qual(rr_q[i])) begin ev = 1; et = rr_q[i]; end
        end else begin
            int best = 0;
            for (int t = 0; t < N; t++)
                if (qual(t) && (!ev || int'(seq[t*SW +: SW]) < best)) begin
                    ev = 1; et = t; best = int'(seq[t*SW +: SW]);
                end
        end
    endfunction

    task automatic cmp(string tag, bit v, int t, bit ev, int et);
        checks++;
        if (v !== ev || t !== et) begin
            errors++;
            $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     tag, v, t, ev, et);
        end
    endtask

    task automatic tick(string tag);
        bit ev; int et; bit sv;
        @(negedge clk); #2;
        model(ev, et);
        cmp(tag, gv, int'(gt), ev, et);
        sv = s_act && (s_stat == 3'd0 || s_stat == 3'd1 || s_stat == 3'd4);
        cmp({tag, "/R11"}, s_gv, int'(s_gt), sv, 0);
        @(posedge clk);
        if (rst) begin
            rr_q = {};
            for (int t = 0; t < N; t++) rr_q.push_back(t);
        end else if (acc && ev && pol == 2'd1) begin
            foreach (rr_q[i]) if (rr_q[i] == et) begin rr_q.delete(i); break; end
            rr_q.push_back(et);
        end
        #1;
    endtask

    task automatic set_thr(int t, int st, bit a, bit e, bit r, int s);
        stat[t*3 +: 3] = 3'(st); act[t] = a; emp[t] = e; rdy[t] = r;
        seq[t*SW +: SW] = SW'(s);
    endtask

    task automatic all_ok();
        for (int t = 0; t < N; t++) set_thr(t, 1, 1, 0, 1, 10 + t);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int t = 0; t < N; t++) rr_q.push_back(t);
        repeat (2) @(posedge clk);
        #1;
        tick("R3 reset");
        tick("R8 reset");
        rst = 1'b0;
        tick("R3");

        // R1: state filtering
        pol = 2'd2;
        set_thr(0, 2, 1, 0, 1, 1); set_thr(1, 3, 1, 0, 1, 2);
        set_thr(2, 4, 1, 0, 1, 9); set_thr(3, 5, 1, 0, 1, 0);
        tick("R1");
        set_thr(2, 0, 1, 0, 1, 9); tick("R1");
        set_thr(2, 7, 1, 0, 1, 9); tick("R1");
        // R2: active, ready and empty flags
        set_thr(0, 1, 1, 0, 0, 1); set_thr(1, 1, 0, 0, 1, 2);
        set_thr(2, 1, 1, 1, 1, 3); set_thr(3, 1, 1, 0, 1, 200);
        tick("R2");
        set_thr(3, 1, 1, 1, 1, 200); tick("R2");
        // R4 / R5 / R6
        set_thr(0, 1, 1, 0, 1, 40); set_thr(1, 1, 1, 0, 1, 12);
        set_thr(2, 0, 1, 0, 1, 30); set_thr(3, 4, 1, 0, 1, 20);
        tick("R4");
        pol = 2'd3; tick("R4");
        pol = 2'd0; tick("R6");
        set_thr(0, 1, 1, 0, 1, 7); set_thr(1, 1, 1, 0, 1, 5);
        set_thr(2, 1, 1, 0, 1, 5); set_thr(3, 1, 1, 0, 1, 9);
        tick("R5"); pol = 2'd2; tick("R5");
        for (int t = 0; t < N; t++) set_thr(t, 1, 1, 0, 1, 33);
        tick("R5");

        // Round-robin: reset order, rotation, holding
        pol = 2'd1; all_ok();
        tick("R8"); tick("R10");
        acc = 1'b1;
        repeat (5) tick("R9");
        acc = 1'b0;
        set_thr(1, 2, 1, 0, 1, 0); tick("R7");
        set_thr(2, 1, 1, 0, 0, 0); tick("R7");
        acc = 1'b1; tick("R9");
        all_ok(); acc = 1'b0; tick("R10");
        pol = 2'd2; acc = 1'b1; tick("R10"); tick("R10");
        pol = 2'd1; acc = 1'b0; tick("R10");
        for (int t = 0; t < N; t++) set_thr(t, 3, 1, 0, 1, 0);
        acc = 1'b1; tick("R3"); all_ok(); acc = 1'b0; tick("R10");

        // Single-thread build
        s_act = 1; s_stat = 3'd1; s_rdy = 0; s_emp = 1; tick("R11");
        s_stat = 3'd4; tick("R11");
        s_stat = 3'd3; tick("R11");
        s_stat = 3'd0; s_act = 0; tick("R11");

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            for (int t = 0; t < N; t++)
                set_thr(t, $urandom_range(0, 7), $urandom_range(0, 7) != 0,
                        $urandom_range(0, 5) == 0, $urandom_range(0, 3) != 0,
                        $urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) pol = 2'($urandom_range(0, 3));
            acc = 1'($urandom_range(0, 1));
            s_act = 1'($urandom_range(0, 1)); s_stat = 3'($urandom_range(0, 7));
            s_rdy = 1'($urandom_range(0, 1)); s_emp = 1'($urandom_range(0, 1));
            tick("R7/R9 mixed");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule